// File: doc/BRIEF.md
# Custom Clock Phase Alignment Sequencer

This block aligns a clock whose frequency differs from the recovered timing clock to the recovered clock's one-second boundary. An example is a 100 MHz clock beside a 125 MHz timing clock. The block runs entirely in the network clock domain.

The sequence has four stages:

1. It waits for the transceiver to lock.
2. It waits for the recovered-domain pulse-per-second alignment to finish.
3. It runs a modulo-N phase counter. N is the timing clock frequency divided by the largest frequency that divides both clocks. For 100 MHz against 125 MHz the common frequency is 25 MHz, so N is 5.
4. At every counter wrap it takes one pair of samples: the level of the recovered clock and the level of the custom clock.

While the samples do not show both rising edges together, the block requests one phase step of the recovered clock from an external phase controller. It then waits for that controller to acknowledge before it samples again. When an edge is found, the block waits for the next pulse-per-second marker, pulses a restart request for pulse-per-second alignment, and then reports completion. A programmable step budget bounds the search. If the budget runs out, a sticky timeout flag is raised.

The phase controller and the transceiver are outside the block. They appear only as the acknowledge input and the status inputs.

Top module: `cca_align_ctrl`

## Requirements
- R1: After reset, `step_req`, `pps_restart`, `align_done` and `timeout_err` are all 0.
- R2: While `cfg_ratio` is 0 or above 16, the block stays idle. It issues no step request and holds `align_done` and `timeout_err` at 0.
- R3: No step request is issued while `link_locked` is 0. After lock, none is issued until `pps_aligned` is 1.
- R4: The phase counter runs from 0 to `cfg_ratio`-1, returns to 0 on `pps_pulse`, and samples at its wrap. With an immediate acknowledge, successive step requests are therefore `cfg_ratio` cycles apart (for `cfg_ratio` of 2 or more).
- R5: `step_req` is a one-cycle pulse. After it, no further sample is taken and no further step is issued until `step_ack` is 1.
- R6: An edge is found when both of these hold:
  - The previous wrap sampled custom=0 and recovered=0.
  - The current wrap samples custom=1 and recovered=1.
  On finding an edge, the block stops issuing steps.
- R7: After an edge is found, the block waits for `pps_pulse`. It then drives `pps_restart` high for exactly one cycle, and from the next cycle holds `align_done` at 1.
- R8: Suppose `cfg_max_steps` steps have been issued, or that value is 0, and a wrap shows no edge. The block then sets `timeout_err`, issues no further steps and stays idle. `timeout_err` clears only when `link_locked` falls or `cfg_ratio` becomes illegal.
- R9: A 0 on `link_locked` in any state returns the block to idle and clears `align_done` on the next cycle.
- R10: A wrap at which the recovered and custom samples disagree never counts as an edge, in either of the two wraps compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ratio | input | 5 | Counter modulus N; legal 1 to 16 |
| cfg_max_steps | input | 8 | Phase-step budget for one search |
| link_locked | input | 1 | Transceiver synchronised to incoming clock |
| pps_aligned | input | 1 | Recovered-domain PPS alignment complete |
| pps_pulse | input | 1 | One-cycle PPS marker in the network domain |
| smp_rec_clk | input | 1 | Sampled level of the recovered clock |
| smp_cust_clk | input | 1 | Sampled level of the custom clock |
| step_ack | input | 1 | Phase controller finished the last step |
| step_req | output | 1 | One-cycle request for one phase step |
| pps_restart | output | 1 | One-cycle request to restart PPS alignment |
| align_done | output | 1 | Alignment complete |
| timeout_err | output | 1 | Step budget exhausted without an edge |

## Verification
The checker watches four things on every cycle:
- the single-cycle width of step and restart pulses;
- the abort on lock loss;
- the idle hold for an illegal modulus;
- the counter staying below the modulus and the exclusion of done and timeout.

Other behaviours are shown only by the bench scenarios:
- how far apart successive step requests are for two different moduli;
- which sample sequences count as an edge, and which mismatched ones do not;
- the exact number of steps before a timeout;
- the ordering of pulse-per-second wait, restart pulse and completion.

// File: rtl/cca_pkg.sv
package cca_pkg;

    localparam int unsigned RATIO_MAX = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_PPS,
        ST_SEARCH,
        ST_WAIT_ACK,
        ST_ALIGN,
        ST_RESTART,
        ST_DONE
    } cca_state_e;

    typedef struct packed {
        logic rec;
        logic cust;
    } clk_sample_t;

    function automatic logic ratio_legal(input int unsigned r);
        return (r >= 1) && (r <= RATIO_MAX);
    endfunction

    // Rising edge seen with both clocks agreeing on both sides of it.
    function automatic logic edge_pair(input clk_sample_t prev, input clk_sample_t cur);
        return !prev.cust && cur.cust && (prev.rec == prev.cust) && (cur.rec == cur.cust);
    endfunction

endpackage

// File: rtl/cca_wrap_counter.sv
module cca_wrap_counter #(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               sync,
    input  logic [RATIO_W-1:0] ratio,
    output logic [RATIO_W-1:0] cnt,
    output logic               wrap
);
    logic [RATIO_W-1:0] last;

    assign last = ratio - RATIO_W'(1);
    assign wrap = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (sync || cnt >= last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + RATIO_W'(1);
        end
    end
endmodule

// File: rtl/cca_edge_track.sv
module cca_edge_track
    import cca_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        capture,
    input  clk_sample_t cur,
    output logic        found
);
    clk_sample_t prev;
    logic        have_prev;

    assign found = have_prev && edge_pair(prev, cur);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev      <= '0;
            have_prev <= 1'b0;
        end else if (capture) begin
            prev      <= cur;
            have_prev <= 1'b1;
        end
    end
endmodule

// File: rtl/cca_step_budget.sv
module cca_step_budget #(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              bump,
    input  logic [STEP_W-1:0] limit,
    output logic              exhausted
);
    logic [STEP_W-1:0] used;

    assign exhausted = (used >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            used <= '0;
        end else if (bump) begin
            used <= used + STEP_W'(1);
        end
    end
endmodule

// File: rtl/cca_align_ctrl.sv
module cca_align_ctrl
    import cca_pkg::*;
#(
    parameter int RATIO_W = 5,
    parameter int STEP_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [STEP_W-1:0]  cfg_max_steps,
    input  logic               link_locked,
    input  logic               pps_aligned,
    input  logic               pps_pulse,
    input  logic               smp_rec_clk,
    input  logic               smp_cust_clk,
    input  logic               step_ack,
    output logic               step_req,
    output logic               pps_restart,
    output logic               align_done,
    output logic               timeout_err
);
    cca_state_e         state;
    logic               go;
    logic               run;
    logic               wrap;
    logic [RATIO_W-1:0] wc_cnt;
    logic               found;
    logic               exhausted;
    logic               search_wrap;
    logic               in_search;
    clk_sample_t        cur_smp;

    assign go          = link_locked && ratio_legal(int'(cfg_ratio));
    assign run         = go && (state != ST_IDLE);
    assign in_search   = (state == ST_SEARCH) || (state == ST_WAIT_ACK);
    assign search_wrap = go && (state == ST_SEARCH) && wrap;
    assign cur_smp     = '{rec: smp_rec_clk, cust: smp_cust_clk};

    cca_wrap_counter #(.RATIO_W(RATIO_W)) wc_i (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .sync  (pps_pulse),
        .ratio (cfg_ratio),
        .cnt   (wc_cnt),
        .wrap  (wrap)
    );

    cca_edge_track et_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (!in_search),
        .capture (search_wrap && !found),
        .cur     (cur_smp),
        .found   (found)
    );

    cca_step_budget #(.STEP_W(STEP_W)) sb_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (!in_search),
        .bump      (search_wrap && !found && !exhausted),
        .limit     (cfg_max_steps),
        .exhausted (exhausted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            step_req    <= 1'b0;
            pps_restart <= 1'b0;
            align_done  <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            step_req    <= 1'b0;
            pps_restart <= 1'b0;
            if (!go) begin
                state       <= ST_IDLE;
                align_done  <= 1'b0;
                timeout_err <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (!timeout_err) state <= ST_WAIT_PPS;
                    end
                    ST_WAIT_PPS: begin
                        if (pps_aligned) state <= ST_SEARCH;
                    end
                    ST_SEARCH: begin
                        if (wrap) begin
                            if (found) begin
                                state <= ST_ALIGN;
                            end else if (exhausted) begin
                                timeout_err <= 1'b1;
                                state       <= ST_IDLE;
                            end else begin
                                step_req <= 1'b1;
                                state    <= ST_WAIT_ACK;
                            end
                        end
                    end
                    ST_WAIT_ACK: begin
                        if (step_ack) state <= ST_SEARCH;
                    end
                    ST_ALIGN: begin
                        if (pps_pulse) begin
                            pps_restart <= 1'b1;
                            state       <= ST_RESTART;
                        end
                    end
                    ST_RESTART: begin
                        align_done <= 1'b1;
                        state      <= ST_DONE;
                    end
                    ST_DONE: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cca_checker.sv
module cca_checker #(
    parameter int RATIO_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               link_locked,
    input logic [RATIO_W-1:0] cfg_ratio,
    input logic [RATIO_W-1:0] cnt,
    input logic               step_req,
    input logic               pps_restart,
    input logic               align_done,
    input logic               timeout_err
);
    logic legal;
    assign legal = (cfg_ratio >= RATIO_W'(1)) && (cfg_ratio <= RATIO_W'(16));

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        step_req |=> !step_req); // R5

    AST_RESTART_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        pps_restart |=> (align_done && !pps_restart)); // R7

    AST_LOCK_ABORT: assert property (@(posedge clk) disable iff (rst)
        !link_locked |=> (!align_done && !step_req && !pps_restart)); // R9

    AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (rst)
        !legal |=> (!step_req && !align_done && !timeout_err)); // R2

    AST_DONE_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(align_done && timeout_err)); // R8

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (legal && $past(cfg_ratio, 1) == cfg_ratio && $past(cfg_ratio, 2) == cfg_ratio)
            |-> (cnt < cfg_ratio)); // R4
endmodule

bind cca_align_ctrl cca_checker #(.RATIO_W(RATIO_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .link_locked (link_locked),
    .cfg_ratio   (cfg_ratio),
    .cnt         (wc_cnt),
    .step_req    (step_req),
    .pps_restart (pps_restart),
    .align_done  (align_done),
    .timeout_err (timeout_err)
);

// File: tb/cca_align_ctrl_tb_top.sv
`timescale 1ns/1ps
module cca_align_ctrl_tb_top;
    localparam int EV_STEP    = 1;
    localparam int EV_RESTART = 2;
    localparam int EV_TMO     = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] cfg_ratio = 5'd5;
    logic [7:0] cfg_max_steps = 8'd20;
    logic       link_locked = 1'b0;
    logic       pps_aligned = 1'b0;
    logic       pps_pulse = 1'b0;
    logic       smp_rec_clk = 1'b0;
    logic       smp_cust_clk = 1'b0;
    logic       step_ack = 1'b0;
    logic       step_req, pps_restart, align_done, timeout_err;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int step_seen = 0;
    int last_step_cyc = 0;
    int step_period = 0;
    bit ack_en = 1'b1;
    bit tmo_prev = 1'b0;
    bit finished = 1'b0;
    int    exp_q[$];
    string req_q[$];

    always #2.5 clk = ~clk;

    cca_align_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_ratio(cfg_ratio), .cfg_max_steps(cfg_max_steps),
        .link_locked(link_locked), .pps_aligned(pps_aligned), .pps_pulse(pps_pulse),
        .smp_rec_clk(smp_rec_clk), .smp_cust_clk(smp_cust_clk), .step_ack(step_ack),
        .step_req(step_req), .pps_restart(pps_restart), .align_done(align_done),
        .timeout_err(timeout_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int ev, input string req);
        exp_q.push_back(ev);
        req_q.push_back(req);
    endtask

    task automatic observe(input int ev);
        int    e;
        string r;
        if (exp_q.size() == 0) begin
            check(1'b0, "unexpected event R2/R3/R5/R6/R8", ev, 0);
        end else begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(e == ev, r, ev, e);
        end
    endtask

    task automatic step_clk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_steps(input int k);
        while (step_seen < k) step_clk(1);
    endtask

    task automatic wait_tmo();
        while (!timeout_err) step_clk(1);
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Monitor: observes events away from the active edge and scores them.
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (step_req) begin
                step_period   = cyc - last_step_cyc;
                last_step_cyc = cyc;
                step_seen++;
                observe(EV_STEP);
            end
            if (pps_restart) observe(EV_RESTART);
            if (timeout_err && !tmo_prev) observe(EV_TMO);
            tmo_prev = timeout_err;
        end
    end

    // Phase controller model: acknowledges each step one cycle later.
    initial forever begin
        @(negedge clk);
        step_ack = step_req && ack_en;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog R1..R10 actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        step_clk(3);
        rst = 1'b0;
        step_clk(1);
        check(!step_req && !pps_restart && !align_done && !timeout_err, "R1 reset outputs",
              {step_req, pps_restart, align_done, timeout_err}, 0);

        // R3: no lock, then lock without pps alignment
        pps_aligned = 1'b1;
        step_clk(30);
        check(step_seen == 0, "R3 no step without lock", step_seen, 0);
        pps_aligned = 1'b0;
        link_locked = 1'b1;
        step_clk(30);
        check(step_seen == 0, "R3 no step before pps aligned", step_seen, 0);

        // R4/R5: modulus 5, constant low samples, steps N apart
        for (int i = 0; i < 3; i++) expect_ev(EV_STEP, "R5 step pulse N=5");
        pps_aligned = 1'b1;
        wait_steps(3);
        check(step_period == 5, "R4 step spacing N=5", step_period, 5);
        link_locked = 1'b0;
        step_clk(20);
        check(step_seen == 3 && !align_done, "R9 abort stops steps", step_seen, 3);

        // R4: modulus 3
        cfg_ratio = 5'd3;
        for (int i = 0; i < 3; i++) expect_ev(EV_STEP, "R5 step pulse N=3");
        link_locked = 1'b1;
        wait_steps(6);
        check(step_period == 3, "R4 step spacing N=3", step_period, 3);
        link_locked = 1'b0;
        step_clk(5);
        check(exp_q.size() == 0, "R4 all expected steps seen", exp_q.size(), 0);

        // R5: withheld acknowledge blocks further sampling
        cfg_ratio = 5'd5;
        ack_en = 1'b0;
        expect_ev(EV_STEP, "R5 first step before ack");
        link_locked = 1'b1;
        wait_steps(7);
        step_clk(40);
        check(step_seen == 7, "R5 no step without ack", step_seen, 7);
        link_locked = 1'b0;
        ack_en = 1'b1;
        step_clk(3);

        // R2: illegal modulus values keep the block idle
        cfg_ratio = 5'd0;
        link_locked = 1'b1;
        step_clk(40);
        check(step_seen == 7 && !timeout_err && !align_done, "R2 ratio 0 idle", step_seen, 7);
        cfg_ratio = 5'd17;
        step_clk(40);
        check(step_seen == 7 && !timeout_err && !align_done, "R2 ratio 17 idle", step_seen, 7);
        link_locked = 1'b0;
        step_clk(2);

        // R6/R7: edge found, then wait for PPS, restart, done
        cfg_ratio = 5'd5;
        smp_rec_clk = 1'b0;
        smp_cust_clk = 1'b0;
        expect_ev(EV_STEP, "R6 one step before edge");
        expect_ev(EV_RESTART, "R7 restart after pps");
        link_locked = 1'b1;
        wait_steps(8);
        smp_rec_clk = 1'b1;
        smp_cust_clk = 1'b1;
        step_clk(40);
        check(step_seen == 8, "R6 stepping stops on edge", step_seen, 8);
        check(!align_done && !pps_restart, "R7 waits for pps", align_done, 0);
        pps_pulse = 1'b1;
        step_clk(1);
        pps_pulse = 1'b0;
        step_clk(2);
        check(align_done == 1'b1, "R7 done after restart", align_done, 1);
        step_clk(20);
        check(align_done == 1'b1 && step_seen == 8, "R7 done holds", align_done, 1);

        // R9: lock loss clears done
        link_locked = 1'b0;
        step_clk(2);
        check(align_done == 1'b0, "R9 done cleared on lock loss", align_done, 0);

        // R10/R8: mismatched samples never count, budget of 3 then timeout
        smp_rec_clk = 1'b0;
        smp_cust_clk = 1'b0;
        cfg_max_steps = 8'd3;
        for (int i = 0; i < 3; i++) expect_ev(EV_STEP, "R10 mismatch keeps stepping");
        expect_ev(EV_TMO, "R8 timeout after budget");
        link_locked = 1'b1;
        wait_steps(9);
        smp_cust_clk = 1'b1;
        wait_steps(10);
        smp_rec_clk = 1'b1;
        wait_steps(11);
        wait_tmo();
        check(step_seen == 11, "R10 no edge from mismatched samples", step_seen, 11);
        step_clk(40);
        check(timeout_err && step_seen == 11 && !align_done, "R8 timeout sticky and idle",
              timeout_err, 1);
        cfg_ratio = 5'd0;
        step_clk(2);
        check(!timeout_err, "R8 timeout clears on illegal ratio", timeout_err, 0);

        // R8: zero budget times out at the first wrap with no step
        smp_rec_clk = 1'b0;
        smp_cust_clk = 1'b0;
        cfg_max_steps = 8'd0;
        cfg_ratio = 5'd4;
        expect_ev(EV_TMO, "R8 zero budget timeout");
        wait_tmo();
        step_clk(2);
        check(step_seen == 11 && timeout_err, "R8 zero budget no step", step_seen, 11);
        link_locked = 1'b0;
        step_clk(2);
        check(!timeout_err, "R8 timeout clears on lock loss", timeout_err, 0);

        check(exp_q.size() == 0, "R5/R6/R7/R8 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule